// File: doc/BRIEF.md
# Bidirectional Segment Shift-Latch Driver

This block loads 64 bits of display segment data over two independent 32-bit serial chains and presents them as per-segment drive-level codes. The low chain holds segments 1 to 32 and the high chain holds segments 33 to 64. Each chain has two serial terminals. A per-chain direction input sets which way the chain shifts. The same input also decides which terminal accepts data and which one drives data out. Several drivers can therefore be cascaded in either orientation.

Both chains shift on every falling edge of the shift clock. A level-sensitive output latch copies the chain contents while the latch pulse is high and holds them while it is low. The display can therefore be refreshed at once after a full line has been shifted in. Each segment output is a 2-bit code that selects one of four drive levels. The code is formed from the latched bit and an alternating drive signal, so the panel sees an AC waveform. The terminals are modelled as separate in, out and output-enable signals.

Top module: `segLatchDriver`

## Requirements
- R1: While `rst` is high at a falling edge of `shiftClk`, both chains clear to zero. While `rst` is high, the output latch is zero, so every segment code reads `{1'b0, altSig}`.
- R2: With `dirLo` high, the low chain takes its input on terminal A1. The bit enters segment 1 and moves one place toward segment 32 per falling edge. Terminal B1 is the enabled output (`ioB1Oe`=1, `ioA1Oe`=0) and drives the current segment-32 bit.
- R3: With `dirLo` low, the low chain takes its input on B1. The bit enters segment 32 and moves toward segment 1. A1 is the enabled output and drives the current segment-1 bit, and `ioB1Oe`=0.
- R4: With `dirHi` high, the high chain takes its input on A2 into segment 33 and shifts toward segment 64. B2 is the enabled output, drives the segment-64 bit, and `ioA2Oe`=0.
- R5: With `dirHi` low, the high chain takes its input on B2 into segment 64 and shifts toward segment 33. A2 is the enabled output, drives the segment-33 bit, and `ioB2Oe`=0.
- R6: The two chains are independent. Each follows only its own direction input and terminals, including when the two directions differ.
- R7: While `latchPulse` is high, the latch is transparent. Segment n's latched bit equals chain bit n.
- R8: While `latchPulse` is low, the latch holds. Shifting does not change the segment codes.
- R9: Segment n (1-based) drives `segCode[2n-1:2n-2]` = {latched bit n, `altSig`}. So 00 means latched 0 with alternate 0, 01 means latched 0 with alternate 1, 10 means latched 1 with alternate 0, and 11 means latched 1 with alternate 1.
- R10: Between falling edges, the chains do not move. The serial outputs keep the values left by the last falling edge. Their enables follow the direction inputs at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shiftClk | input | 1 | Shift clock; chains move on its falling edge |
| rst | input | 1 | Synchronous active-high clear of chains and latch |
| latchPulse | input | 1 | High: latch transparent; low: latch holds |
| altSig | input | 1 | Alternating drive signal |
| dirLo | input | 1 | Low-chain direction (1: A1 in, toward segment 32) |
| dirHi | input | 1 | High-chain direction (1: A2 in, toward segment 64) |
| ioA1In | input | 1 | Terminal A1 input value |
| ioA1Out | output | 1 | Terminal A1 output value |
| ioA1Oe | output | 1 | Terminal A1 output enable |
| ioB1In | input | 1 | Terminal B1 input value |
| ioB1Out | output | 1 | Terminal B1 output value |
| ioB1Oe | output | 1 | Terminal B1 output enable |
| ioA2In | input | 1 | Terminal A2 input value |
| ioA2Out | output | 1 | Terminal A2 output value |
| ioA2Oe | output | 1 | Terminal A2 output enable |
| ioB2In | input | 1 | Terminal B2 input value |
| ioB2Out | output | 1 | Terminal B2 output value |
| ioB2Oe | output | 1 | Terminal B2 output enable |
| segCode | output | 128 | Two-bit drive code per segment, segment 1 in bits 1:0 |

## Verification
The assertions watch every falling edge for four things. They check that the clear happened, that the bit on the active input terminal landed at the correct end of its chain, and that the chain moved by exactly one place in the selected direction. They also check that the latch followed the chain while open and stayed put while closed. Some behaviour only the bench scenarios can show. These are the drive code encoding over all four level combinations, the serial outputs seen at the terminals, and the chains running in opposite directions at once. They also include the outputs staying still between falling edges, and long shifts with the latch closed followed by a single latch pulse.

// File: rtl/segDrvPkg.sv
package segDrvPkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic clearAll;
    logic latchOpen;
    logic loShiftUp;
    logic hiShiftUp;
  } drvStrobes_t;
endpackage

// File: rtl/segDrvCtrl.sv
module segDrvCtrl
  import segDrvPkg::*;
(
  input  logic        rst,
  input  logic        latchPulse,
  input  logic        dirLo,
  input  logic        dirHi,
  output drvStrobes_t strobes
);
  always_comb begin
    strobes.clearAll  = rst;
    strobes.latchOpen = latchPulse & ~rst;
    strobes.loShiftUp = dirLo;
    strobes.hiShiftUp = dirHi;
  end
endmodule

// File: rtl/segShiftHalf.sv
module segShiftHalf #(
  parameter int HALF_W = 32
) (
  input  logic              shiftClk,
  input  logic              clear,
  input  logic              shiftUp,
  input  logic              pinAIn,
  input  logic              pinBIn,
  output logic              pinAOut,
  output logic              pinAOe,
  output logic              pinBOut,
  output logic              pinBOe,
  output logic [HALF_W-1:0] bits
);
  localparam int TOP = HALF_W - 1;

  always_ff @(negedge shiftClk) begin
    if (clear)        bits <= '0;
    else if (shiftUp) bits <= {bits[TOP-1:0], pinAIn};
    else              bits <= {pinBIn, bits[TOP:1]};
  end

  // Far end of chain drives the terminal that is not the input
  always_comb begin
    pinAOut = bits[0];
    pinBOut = bits[TOP];
    pinAOe  = ~shiftUp;
    pinBOe  = shiftUp;
  end

  // R1: clear empties the chain
  assert_clear_chain_R1: assert property (@(negedge shiftClk)
    clear |=> (bits == '0));
  // R2/R4: upward entry on terminal A
  assert_enter_up_R2: assert property (@(negedge shiftClk) disable iff (clear)
    shiftUp |=> (bits[0] == $past(pinAIn)));
  // R3/R5: downward entry on terminal B
  assert_enter_down_R3: assert property (@(negedge shiftClk) disable iff (clear)
    !shiftUp |=> (bits[TOP] == $past(pinBIn)));
  // R2/R4: one-place move upward
  assert_move_up_R4: assert property (@(negedge shiftClk) disable iff (clear)
    shiftUp |=> (bits[TOP:1] == $past(bits[TOP-1:0])));
  // R3/R5: one-place move downward
  assert_move_down_R5: assert property (@(negedge shiftClk) disable iff (clear)
    !shiftUp |=> (bits[TOP-1:0] == $past(bits[TOP:1])));
endmodule

// File: rtl/segDrvOut.sv
module segDrvOut #(
  parameter int SEG_N = 64
) (
  input  logic               clear,
  input  logic               latchOpen,
  input  logic               altSig,
  input  logic [SEG_N-1:0]   chain,
  output logic [SEG_N-1:0]   latched,
  output logic [2*SEG_N-1:0] segCode
);
  // Level-sensitive output latch
  always_latch begin
    if (clear)          latched <= '0;
    else if (latchOpen) latched <= chain;
  end

  for (genvar i = 0; i < SEG_N; i++) begin : g_enc
    assign segCode[2*i+1 -: 2] = {latched[i], altSig};
  end
endmodule

// File: rtl/segLatchDriver.sv
module segLatchDriver
  import segDrvPkg::*;
#(
  parameter int HALF_W = 32
) (
  input  logic                  shiftClk,
  input  logic                  rst,
  input  logic                  latchPulse,
  input  logic                  altSig,
  input  logic                  dirLo,
  input  logic                  dirHi,
  input  logic                  ioA1In,
  output logic                  ioA1Out,
  output logic                  ioA1Oe,
  input  logic                  ioB1In,
  output logic                  ioB1Out,
  output logic                  ioB1Oe,
  input  logic                  ioA2In,
  output logic                  ioA2Out,
  output logic                  ioA2Oe,
  input  logic                  ioB2In,
  output logic                  ioB2Out,
  output logic                  ioB2Oe,
  output logic [4*HALF_W-1:0]   segCode
);
  localparam int SEG_N = 2 * HALF_W;

  drvStrobes_t       strobes;
  logic [HALF_W-1:0] loBits, hiBits;
  logic [SEG_N-1:0]  chainAll, latchedAll;

  segDrvCtrl u_ctrl (
    .rst(rst), .latchPulse(latchPulse), .dirLo(dirLo), .dirHi(dirHi),
    .strobes(strobes)
  );

  segShiftHalf #(.HALF_W(HALF_W)) u_lo (
    .shiftClk(shiftClk), .clear(strobes.clearAll), .shiftUp(strobes.loShiftUp),
    .pinAIn(ioA1In), .pinBIn(ioB1In),
    .pinAOut(ioA1Out), .pinAOe(ioA1Oe), .pinBOut(ioB1Out), .pinBOe(ioB1Oe),
    .bits(loBits)
  );

  segShiftHalf #(.HALF_W(HALF_W)) u_hi (
    .shiftClk(shiftClk), .clear(strobes.clearAll), .shiftUp(strobes.hiShiftUp),
    .pinAIn(ioA2In), .pinBIn(ioB2In),
    .pinAOut(ioA2Out), .pinAOe(ioA2Oe), .pinBOut(ioB2Out), .pinBOe(ioB2Oe),
    .bits(hiBits)
  );

  assign chainAll = {hiBits, loBits};

  segDrvOut #(.SEG_N(SEG_N)) u_out (
    .clear(strobes.clearAll), .latchOpen(strobes.latchOpen), .altSig(altSig),
    .chain(chainAll), .latched(latchedAll), .segCode(segCode)
  );

  // R7: open latch tracks the chains
  assert_latch_follow_R7: assert property (@(negedge shiftClk) disable iff (rst)
    latchPulse |-> (latchedAll == chainAll));
  // R8: closed latch keeps its contents across a shift
  assert_latch_hold_R8: assert property (@(negedge shiftClk) disable iff (rst)
    !latchPulse |=> (!latchPulse -> $stable(latchedAll)));
endmodule

// File: tb/sim_segLatchDriver.sv
module sim_segLatchDriver;
  localparam int HW = 32;
  localparam int SN = 2 * HW;

  logic shiftClk = 1'b1;
  logic rst = 1'b1, latchPulse = 1'b0, altSig = 1'b0, dirLo = 1'b1, dirHi = 1'b1;
  logic ioA1In = 0, ioB1In = 0, ioA2In = 0, ioB2In = 0;
  logic ioA1Out, ioA1Oe, ioB1Out, ioB1Oe, ioA2Out, ioA2Oe, ioB2Out, ioB2Oe;
  logic [2*SN-1:0] segCode;

  int errors = 0, checks = 0;
  logic [HW-1:0] mLo = '0, mHi = '0;
  logic [SN-1:0] mLat = '0;

  always #5 shiftClk = ~shiftClk;

  segLatchDriver #(.HALF_W(HW)) u0 (.*);

  function automatic logic [2*SN-1:0] expCodes(logic [SN-1:0] lat, logic alt);
    logic [2*SN-1:0] c;
    for (int i = 0; i < SN; i++) c[2*i+1 -: 2] = {lat[i], alt};
    return c;
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Serial terminals against model (oe always, value only when enabled)
  task automatic chkPins(string req);
    chk(req, {126'd0, ioA1Oe, ioB1Oe}, {126'd0, ~dirLo, dirLo});
    chk(req, {126'd0, ioA2Oe, ioB2Oe}, {126'd0, ~dirHi, dirHi});
    if (dirLo) chk(req, {127'd0, ioB1Out}, {127'd0, mLo[HW-1]});
    else       chk(req, {127'd0, ioA1Out}, {127'd0, mLo[0]});
    if (dirHi) chk(req, {127'd0, ioB2Out}, {127'd0, mHi[HW-1]});
    else       chk(req, {127'd0, ioA2Out}, {127'd0, mHi[0]});
  endtask

  task automatic step(logic r, logic l, logic a, logic dl, logic dh,
                      logic a1, logic b1, logic a2, logic b2, string req);
    @(posedge shiftClk); #1;
    rst = r; latchPulse = l; altSig = a; dirLo = dl; dirHi = dh;
    ioA1In = a1; ioB1In = b1; ioA2In = a2; ioB2In = b2;
    #1;
    chkPins("R10 pre-edge pins");
    if (r) begin mLo = '0; mHi = '0; end
    else begin
      mLo = dl ? {mLo[HW-2:0], a1} : {b1, mLo[HW-1:1]};
      mHi = dh ? {mHi[HW-2:0], a2} : {b2, mHi[HW-1:1]};
    end
    if (r) mLat = '0; else if (l) mLat = {mHi, mLo};
    @(negedge shiftClk); #2;
    chk(req, segCode, expCodes(mLat, a));
    chkPins(req);
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    void'($urandom(32'd1234));
    // R1: reset state, both alternate levels
    step(1, 0, 0, 1, 1, 1, 1, 1, 1, "R1 reset alt0");
    step(1, 1, 1, 1, 1, 1, 1, 1, 1, "R1 reset alt1");
    // R2 + R8: low up, high up, latch closed
    for (int i = 0; i < 40; i++) begin
      rv = $urandom;
      step(0, 0, rv[4], 1, 1, rv[0], rv[1], rv[2], rv[3], "R2 R4 R8 shift up closed");
    end
    step(0, 1, 0, 1, 1, 1, 0, 0, 1, "R7 R9 latch alt0");
    step(0, 1, 1, 1, 1, 0, 1, 1, 0, "R7 R9 latch alt1");
    // R6: opposite directions
    for (int i = 0; i < 40; i++) begin
      rv = $urandom;
      step(0, 0, rv[4], 0, 1, rv[0], rv[1], rv[2], rv[3], "R3 R6 R8 lo down hi up");
    end
    step(0, 1, 0, 0, 1, 0, 1, 1, 0, "R6 R7 latch");
    for (int i = 0; i < 40; i++) begin
      rv = $urandom;
      step(0, rv[5], rv[4], 1, 0, rv[0], rv[1], rv[2], rv[3], "R5 R6 lo up hi down");
    end
    for (int i = 0; i < 40; i++) begin
      rv = $urandom;
      step(0, rv[5], rv[4], 0, 0, rv[0], rv[1], rv[2], rv[3], "R3 R5 both down");
    end
    // R9: all ones latched, all four codes seen
    for (int i = 0; i < 70; i++) step(0, 1, i[0], 1, 1, 1, 1, 1, 1, "R9 ones");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 R9 hold code 10");
    step(0, 0, 1, 0, 0, 0, 0, 0, 0, "R8 R9 hold code 11");
    step(1, 0, 1, 1, 1, 1, 1, 1, 1, "R1 reset after ones");
    // Random mix
    for (int i = 0; i < 600; i++) begin
      rv = $urandom;
      step(rv[10:6] == 0, rv[5], rv[4], rv[7], rv[8],
           rv[0], rv[1], rv[2], rv[3], "R6 R7 R8 random");
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule